// File: doc/BRIEF.md
# Loop Predicate Generator

This block produces the per-lane activity mask that steers a scalable vector loop, together with the four condition flags that loop-control branches test. A request presents an element size, a generation mode and a governing mask. In bounded-count mode the block compares a 64-bit start index against a 64-bit end index. The lanes whose index plus lane number stays below the end are switched on, so a loop's last, partial iteration needs no separate scalar tail. In fill mode a pattern code picks how many leading lanes are switched on.

The mask uses one bit per vector byte. A lane wider than a byte is represented only by the bit at its lowest byte, and every other bit of that lane is driven low. The result is the generated lane pattern combined with the governing mask. The flags describe that result as seen through the governing mask: whether the first enabled lane is on, whether no lane is on, and whether the last enabled lane is off. The overflow flag is always cleared.

A two-state controller holds the result. State IDLE moves to OUT when a request is seen, and OUT stays in OUT while requests keep coming. Either state returns to or stays in IDLE when no request is present. The output registers load only on a request, and the valid output is high exactly in state OUT.

Top module: `lpg_top`

## Requirements
- R1: A request sampled at a rising edge yields valid_o high and the new pred_o/flags_o from that edge on. With no request at an edge, valid_o is low after it and pred_o and flags_o keep their values.
- R2: esize_i selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. The lane count is the mask width divided by 1, 2, 4 or 8. Lane k is carried on pred_o bit k·(width/8), and all other bits of a wider lane are 0.
- R3: In bounded-count mode (mode_i = 0) with sign_i = 0, lane k is on exactly when start_i + k < end_i as unsigned 64-bit values. The sum is assumed not to wrap.
- R4: With sign_i = 1 the same comparison is made on two's-complement signed values.
- R5: In fill mode (mode_i = 1), pattern_i picks the count of leading lanes that are on: 0 = all lanes, 1 = the largest multiple of 4, 2 = the largest multiple of 3, 3 = none.
- R6: A lane is on in pred_o only if gov_i is set at the lane's lowest byte position.
- R7: flags_o[3] (N) is 1 when the lowest lane enabled in gov_i is on in pred_o.
- R8: flags_o[2] (Z) is 1 when no lane is on in pred_o.
- R9: flags_o[1] (C) is 1 when the highest lane enabled in gov_i is off in pred_o.
- R10: flags_o[0] (V) is always 0. When gov_i enables no lane, the flags are N=0, Z=1, C=1.
- R11: While rst_n is low, valid_o, pred_o and flags_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 bounded-count, 1 fill |
| sign_i | input | 1 | Signed index comparison |
| esize_i | input | 2 | Lane width code |
| pattern_i | input | 2 | Fill pattern code |
| start_i | input | 64 | First index |
| end_i | input | 64 | Bound index |
| gov_i | input | PW | Governing mask, one bit per byte |
| valid_o | output | 1 | Result valid |
| pred_o | output | PW | Generated mask, one bit per byte |
| flags_o | output | 4 | N, Z, C, V from bit 3 down |

## Verification
The bench targets indices that sit on opposite sides of the sign boundary. A design that ignored sign_i would give full masks where it should give empty ones, and empty masks where it should give full ones. It runs fill patterns whose multiple-of-3 count falls below the lane count; an off-by-one there leaves a stray lane on. Governing masks with holes at the first or last lane, or with bits only at non-significant byte positions, expose N and C taken from raw lane 0 or the top lane instead of the enabled lanes. They also expose lanes built from the wrong byte of a wide element. A held-output check catches registers that load without a request.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        PAT_ALL  = 2'd0,
        PAT_MUL4 = 2'd1,
        PAT_MUL3 = 2'd2,
        PAT_NONE = 2'd3
    } pattern_e;

    typedef enum logic {
        GEN_BOUND = 1'b0,
        GEN_FILL  = 1'b1
    } gen_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } fsm_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/lpg_lane_count.sv
module lpg_lane_count #(
    parameter int PW    = 64,
    parameter int CNT_W = $clog2(PW + 1)
) (
    input  logic             mode_i,
    input  logic             sign_i,
    input  logic [1:0]       esize_i,
    input  logic [1:0]       pattern_i,
    input  logic [63:0]      start_i,
    input  logic [63:0]      end_i,
    output logic [CNT_W-1:0] count_o
);
    import lpg_pkg::*;

    localparam int L8  = PW;
    localparam int L16 = PW / 2;
    localparam int L32 = PW / 4;
    localparam int L64 = PW / 8;

    logic [CNT_W-1:0] nlanes;
    logic [CNT_W-1:0] nmul3;
    logic [CNT_W-1:0] nmul4;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] bound_cnt;
    logic             above;
    logic [63:0]      span;

    // lane totals and their rounded-down multiples per element width
    always_comb begin
        unique case (esize_e'(esize_i))
            ESZ_8: begin
                nlanes = CNT_W'(L8);
                nmul3  = CNT_W'((L8 / 3) * 3);
                nmul4  = CNT_W'((L8 / 4) * 4);
            end
            ESZ_16: begin
                nlanes = CNT_W'(L16);
                nmul3  = CNT_W'((L16 / 3) * 3);
                nmul4  = CNT_W'((L16 / 4) * 4);
            end
            ESZ_32: begin
                nlanes = CNT_W'(L32);
                nmul3  = CNT_W'((L32 / 3) * 3);
                nmul4  = CNT_W'((L32 / 4) * 4);
            end
            default: begin
                nlanes = CNT_W'(L64);
                nmul3  = CNT_W'((L64 / 3) * 3);
                nmul4  = CNT_W'((L64 / 4) * 4);
            end
        endcase
    end

    always_comb begin
        unique case (pattern_e'(pattern_i))
            PAT_ALL:  fill_cnt = nlanes;
            PAT_MUL4: fill_cnt = nmul4;
            PAT_MUL3: fill_cnt = nmul3;
            default:  fill_cnt = '0;
        endcase
    end

    // lanes on form a prefix: count = clamp(end - start, 0, nlanes)
    always_comb begin
        if (sign_i) begin
            above = $signed(end_i) > $signed(start_i);
        end else begin
            above = end_i > start_i;
        end
        span = end_i - start_i;
        if (!above) begin
            bound_cnt = '0;
        end else if (span >= 64'(nlanes)) begin
            bound_cnt = nlanes;
        end else begin
            bound_cnt = span[CNT_W-1:0];
        end
    end

    assign count_o = (gen_mode_e'(mode_i) == GEN_FILL) ? fill_cnt : bound_cnt;

endmodule

// File: rtl/lpg_mask_expand.sv
module lpg_mask_expand #(
    parameter int PW    = 64,
    parameter int CNT_W = $clog2(PW + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       esize_i,
    input  logic [PW-1:0]    gov_i,
    output logic [PW-1:0]    pred_o
);
    localparam int IDX_W = CNT_W + 1;

    for (genvar j = 0; j < PW; j++) begin : g_byte
        logic [IDX_W-1:0] lane_idx;
        logic [IDX_W-1:0] low_mask;
        logic             is_low;

        assign lane_idx = IDX_W'(j) >> esize_i;
        assign low_mask = (IDX_W'(1) << esize_i) - IDX_W'(1);
        assign is_low   = (IDX_W'(j) & low_mask) == '0;
        assign pred_o[j] = is_low && (lane_idx < IDX_W'(count_i)) && gov_i[j];
    end

endmodule

// File: rtl/lpg_flag_eval.sv
module lpg_flag_eval #(
    parameter int PW = 64
) (
    input  logic [PW-1:0]  pred_i,
    input  logic [PW-1:0]  gov_i,
    input  logic [1:0]     esize_i,
    output lpg_pkg::nzcv_t flags_o
);
    logic [PW-1:0] enabled;
    logic          seen;
    int            stride;

    always_comb begin
        stride = 1 << int'(esize_i);
        for (int j = 0; j < PW; j++) begin
            enabled[j] = gov_i[j] && ((j % stride) == 0);
        end
    end

    always_comb begin
        seen      = 1'b0;
        flags_o.n = 1'b0;
        flags_o.c = 1'b1;
        // first enabled lane decides N, the last one overwrites C
        for (int j = 0; j < PW; j++) begin
            if (enabled[j]) begin
                if (!seen) begin
                    flags_o.n = pred_i[j];
                end
                seen      = 1'b1;
                flags_o.c = !pred_i[j];
            end
        end
        flags_o.z = ((pred_i & enabled) == '0);
        flags_o.v = 1'b0;
    end

endmodule

// File: rtl/lpg_top.sv
module lpg_top #(
    parameter int VL_BITS = 512,
    parameter int PW      = VL_BITS / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          mode_i,
    input  logic          sign_i,
    input  logic [1:0]    esize_i,
    input  logic [1:0]    pattern_i,
    input  logic [63:0]   start_i,
    input  logic [63:0]   end_i,
    input  logic [PW-1:0] gov_i,
    output logic          valid_o,
    output logic [PW-1:0] pred_o,
    output logic [3:0]    flags_o
);
    import lpg_pkg::*;

    // VL_BITS is expected to be a multiple of 128, at most 2048
    localparam int CNT_W = $clog2(PW + 1);

    fsm_e             state_q;
    fsm_e             state_d;
    logic [CNT_W-1:0] lane_cnt;
    logic [PW-1:0]    pred_d;
    nzcv_t            flags_d;
    logic [PW-1:0]    pred_q;
    nzcv_t            flags_q;

    lpg_lane_count #(.PW(PW), .CNT_W(CNT_W)) u_count (
        .mode_i    (mode_i),
        .sign_i    (sign_i),
        .esize_i   (esize_i),
        .pattern_i (pattern_i),
        .start_i   (start_i),
        .end_i     (end_i),
        .count_o   (lane_cnt)
    );

    lpg_mask_expand #(.PW(PW), .CNT_W(CNT_W)) u_expand (
        .count_i (lane_cnt),
        .esize_i (esize_i),
        .gov_i   (gov_i),
        .pred_o  (pred_d)
    );

    lpg_flag_eval #(.PW(PW)) u_flags (
        .pred_i  (pred_d),
        .gov_i   (gov_i),
        .esize_i (esize_i),
        .flags_o (flags_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = req_i ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q  <= '0;
            flags_q <= '0;
        end else if (req_i) begin
            pred_q  <= pred_d;
            flags_q <= flags_d;
        end
    end

    assign valid_o = (state_q == ST_OUT);
    assign pred_o  = pred_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
    parameter int PW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          mode_i,
    input logic [1:0]    esize_i,
    input logic [1:0]    pattern_i,
    input logic [PW-1:0] gov_i,
    input logic          valid_o,
    input logic [PW-1:0] pred_o,
    input logic [3:0]    flags_o
);
    function automatic logic [PW-1:0] upper_bytes(input logic [1:0] e);
        logic [PW-1:0] m;
        m = '0;
        for (int j = 0; j < PW; j++) begin
            if ((j % (1 << int'(e))) != 0) m[j] = 1'b1;
        end
        return m;
    endfunction

    assert_valid_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && $stable(pred_o) && $stable(flags_o)));

    assert_upper_bytes_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ((pred_o & upper_bytes($past(esize_i))) == '0));

    assert_fill_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i && pattern_i == 2'd3) |=> (pred_o == '0));

    assert_inside_gov_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ((pred_o & ~$past(gov_i)) == '0));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flags_o[2] == (pred_o == '0)));

    assert_v_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !flags_o[0]);

    assert_empty_gov_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && gov_i == '0) |=> (flags_o == 4'b0110));

endmodule

bind lpg_top lpg_checker #(.PW(PW)) u_lpg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .mode_i    (mode_i),
    .esize_i   (esize_i),
    .pattern_i (pattern_i),
    .gov_i     (gov_i),
    .valid_o   (valid_o),
    .pred_o    (pred_o),
    .flags_o   (flags_o)
);

// File: tb/tb_lpg_top.sv
module tb_lpg_top;

    localparam int PW = 64;

    typedef struct packed {
        logic        mode;
        logic        sgn;
        logic [1:0]  esz;
        logic [1:0]  pat;
        logic [63:0] st;
        logic [63:0] en;
        logic [8:0]  cnt;
        logic [3:0]  fl;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] NEG16 = 64'hFFFF_FFFF_FFFF_FFF0;
    localparam logic [63:0] NEG1  = 64'hFFFF_FFFF_FFFF_FFFF;

    // full governing mask; flags nibble = N Z C V
    localparam vec_t VECS [0:12] = '{
        '{1'b0, 1'b0, 2'd0, 2'd0, 64'd0,   64'd10,  9'd10, 4'hA, 4'd3}, // R3 partial
        '{1'b0, 1'b0, 2'd2, 2'd0, 64'd100, 64'd200, 9'd16, 4'h8, 4'd3}, // R3 full
        '{1'b0, 1'b0, 2'd3, 2'd0, 64'd5,   64'd5,   9'd0,  4'h6, 4'd9}, // R9 empty
        '{1'b0, 1'b0, 2'd1, 2'd0, 64'd7,   64'd20,  9'd13, 4'hA, 4'd2}, // R2 16-bit
        '{1'b0, 1'b0, 2'd0, 2'd0, NEG16,   64'd3,   9'd0,  4'h6, 4'd4}, // R4 unsigned
        '{1'b0, 1'b1, 2'd0, 2'd0, NEG16,   64'd3,   9'd19, 4'hA, 4'd4}, // R4 signed
        '{1'b0, 1'b1, 2'd0, 2'd0, 64'd5,   NEG1,    9'd0,  4'h6, 4'd4}, // R4 signed
        '{1'b1, 1'b0, 2'd2, 2'd0, 64'd0,   64'd0,   9'd16, 4'h8, 4'd5}, // R5 all
        '{1'b1, 1'b0, 2'd0, 2'd2, 64'd0,   64'd0,   9'd63, 4'hA, 4'd5}, // R5 mul3
        '{1'b1, 1'b0, 2'd3, 2'd2, 64'd0,   64'd0,   9'd6,  4'hA, 4'd5}, // R5 mul3
        '{1'b1, 1'b0, 2'd3, 2'd1, 64'd0,   64'd0,   9'd8,  4'h8, 4'd5}, // R5 mul4
        '{1'b1, 1'b0, 2'd1, 2'd3, 64'd0,   64'd0,   9'd0,  4'h6, 4'd5}, // R5 none
        '{1'b0, 1'b0, 2'd3, 2'd0, 64'd0,   64'd3,   9'd3,  4'hA, 4'd7}  // R7 64-bit
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          sign_i = 1'b0;
    logic [1:0]    esize_i = '0;
    logic [1:0]    pattern_i = '0;
    logic [63:0]   start_i = '0;
    logic [63:0]   end_i = '0;
    logic [PW-1:0] gov_i = '0;
    logic          valid_o;
    logic [PW-1:0] pred_o;
    logic [3:0]    flags_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpg_top #(.VL_BITS(512)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .mode_i    (mode_i),
        .sign_i    (sign_i),
        .esize_i   (esize_i),
        .pattern_i (pattern_i),
        .start_i   (start_i),
        .end_i     (end_i),
        .gov_i     (gov_i),
        .valid_o   (valid_o),
        .pred_o    (pred_o),
        .flags_o   (flags_o)
    );

    function automatic logic [PW-1:0] model_pred(input int cnt, input int esz,
                                                 input logic [PW-1:0] gov);
        logic [PW-1:0] p;
        int e;
        p = '0;
        e = 1 << esz;
        for (int j = 0; j < PW; j++) begin
            if ((j % e) == 0 && (j / e) < cnt && gov[j]) p[j] = 1'b1;
        end
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic md, input logic sg, input logic [1:0] es,
                         input logic [1:0] pt, input logic [63:0] st,
                         input logic [63:0] en, input logic [PW-1:0] gv);
        @(negedge clk);
        mode_i = md; sign_i = sg; esize_i = es; pattern_i = pt;
        start_i = st; end_i = en; gov_i = gv; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [PW-1:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 valid", 64'(valid_o), 64'd0);
        check("R11 pred", pred_o, 64'd0);
        check("R11 flags", 64'(flags_o), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i <= 12; i++) begin
            apply(VECS[i].mode, VECS[i].sgn, VECS[i].esz, VECS[i].pat,
                  VECS[i].st, VECS[i].en, '1);
            check($sformatf("R1 valid vec%0d", i), 64'(valid_o), 64'd1);
            check($sformatf("R%0d pred vec%0d", VECS[i].req, i), pred_o,
                  model_pred(int'(VECS[i].cnt), int'(VECS[i].esz), '1));
            check($sformatf("R%0d flags vec%0d", VECS[i].req, i), 64'(flags_o),
                  64'(VECS[i].fl));
        end

        // R10 no enabled lane
        apply(1'b0, 1'b0, 2'd0, 2'd0, 64'd0, 64'd10, '0);
        check("R10 pred", pred_o, 64'd0);
        check("R10 flags", 64'(flags_o), 64'h6);

        // R6 and R7: first lane masked off, N taken from lane 1
        apply(1'b0, 1'b0, 2'd0, 2'd0, 64'd0, 64'd10, ~64'd1);
        check("R6 pred", pred_o, 64'h3FE);
        check("R7 flags", 64'(flags_o), 64'hA);

        // R8: enabled lanes all beyond the count
        apply(1'b0, 1'b0, 2'd0, 2'd0, 64'd0, 64'd10, 64'hFF00_0000_0000_0000);
        check("R8 pred", pred_o, 64'd0);
        check("R8 flags", 64'(flags_o), 64'h6);

        // R9: top lane masked off, last enabled lane is on so C=0
        apply(1'b0, 1'b0, 2'd0, 2'd0, 64'd0, 64'd100, ~(64'd1 << 63));
        check("R9 pred", pred_o, ~(64'd1 << 63));
        check("R9 flags", 64'(flags_o), 64'h8);

        // R2: gov only at non-significant bytes of 16-bit lanes
        apply(1'b0, 1'b0, 2'd1, 2'd0, 64'd0, 64'd100, 64'hAAAA_AAAA_AAAA_AAAA);
        check("R2 pred", pred_o, 64'd0);
        check("R2 flags", 64'(flags_o), 64'h6);

        // R4 extreme signed span; R3 same operands unsigned
        apply(1'b0, 1'b1, 2'd0, 2'd0, 64'h8000_0000_0000_0000,
              64'h7FFF_FFFF_FFFF_FFFF, '1);
        check("R4 pred", pred_o, '1);
        check("R4 flags", 64'(flags_o), 64'h8);
        apply(1'b0, 1'b0, 2'd0, 2'd0, 64'h8000_0000_0000_0000,
              64'h7FFF_FFFF_FFFF_FFFF, '1);
        check("R3 pred", pred_o, 64'd0);
        check("R3 flags", 64'(flags_o), 64'h6);

        // R1 hold: change inputs without a request
        apply(1'b0, 1'b0, 2'd0, 2'd0, 64'd0, 64'd5, '1);
        held = pred_o;
        check("R1 pred", held, 64'h1F);
        end_i = 64'd40;
        @(negedge clk);
        check("R1 idle valid", 64'(valid_o), 64'd0);
        check("R1 held pred", pred_o, held);
        check("R1 held flags", 64'(flags_o), 64'hA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule